// File: doc/BRIEF.md
# Fine Phase Step Controller

This block holds the signed phase-offset setting that a clock generator's delay stage reads. All of its logic runs on one control clock. A parameter picks one of three modes at build time. In the off mode the offset is zero. In the static mode the offset is a constant taken from a parameter. In the stepping mode the offset starts at that constant, and single-unit requests move it up or down.

In the stepping mode, a request is a one-cycle pulse on `step_req`. The level of `step_up` in the same cycle sets the direction. The block accepts the request, waits a fixed number of control-clock cycles set by a parameter, and then updates the offset. In the same cycle it answers with a one-cycle `step_done` pulse. The offset is bounded to plus or minus 255. A step that would cross the bound is refused: the offset stays where it is, the done pulse still comes, and a refusal flag is raised. The current offset is always visible on `phase_ofs` so that a delay model downstream can apply it.

Top module: `phase_step_ctrl`

## Requirements
- R1: While `ctl_rst_n` is low and after its release, until the first step completes, `phase_ofs` equals the parameter `INIT_OFS` (clamped to ±255) in the static and stepping modes and 0 in the off mode. `step_done` and `ofs_refused` are 0 during this time.
- R2: In the stepping mode, a request is accepted when `step_req` is 1 at a rising edge and no request is pending. On completion the offset becomes the old value +1 if `step_up` was 1 at the accepting edge, or −1 if it was 0.
- R3: `phase_ofs` never leaves the range −255..+255. A step up from +255 or a step down from −255 leaves the offset unchanged, still produces `step_done`, and sets `ofs_refused` to 1 in the same cycle.
- R4: `ofs_refused` keeps its value until the next step completes. It is cleared when that step succeeds.
- R5: `step_done` is 1 for exactly one cycle. That cycle follows the `LATENCY`-th rising edge after the accepting edge, and the new `phase_ofs` is visible in the same cycle.
- R6: `step_req` pulses that arrive while a request is pending are ignored. This includes a pulse at the edge that completes the pending request. An ignored pulse produces no extra done and no offset change, and `step_up` has no effect outside an accepting edge.
- R7: In the off and static modes all requests are ignored, `step_done` is never 1, and `phase_ofs` never changes.
- R8: `phase_ofs` changes only in a cycle in which `step_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock; all inputs are sampled on its rising edge |
| ctl_rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| step_req | input | 1 | Step request, one cycle per request |
| step_up | input | 1 | Direction with the request: 1 = increase, 0 = decrease |
| phase_ofs | output | 9 | Current signed offset, two's complement |
| step_done | output | 1 | One-cycle answer to each accepted request |
| ofs_refused | output | 1 | 1 when the last completed step was blocked at the bound |

## Verification
Three events can fall in the same cycle. A completing step can coincide with the offset reaching a bound. A new request can arrive on the very edge that completes the pending one. The bench provokes both. It drives runs of steps into +255 and −255. While each request is pending it holds `step_req` high at random, so one of those pulses lands on the completing edge. Each case is judged at the ports. The offset must hold and the refusal flag must rise together with the single done pulse. In the cycle after that pulse, neither a second done nor an offset change may appear.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_FIXED = 2'd1,
    PS_STEP  = 2'd2
  } ps_mode_e;

  // Bring a requested start offset inside the legal window.
  function automatic int clamp_ofs(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/phase_step_seq.sv
// Request acceptance, pending window and done pulse.
module phase_step_seq #(
  parameter int unsigned LATENCY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic req,
  input  logic up,
  output logic apply,
  output logic apply_up,
  output logic done
);

  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             done_q, done_d;
  logic             accept, finish, cnt_en, up_en;

  always_comb begin
    accept = arm && req && !busy_q;
    finish = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    up_d   = up_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    up_en  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
      up_d   = up;
      up_en  = 1'b1;
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
    end else if (up_en) begin
      up_q <= up_d;
    end
  end

  assign apply    = finish;
  assign apply_up = up_q;
  assign done     = done_q;

endmodule

// File: rtl/phase_ofs_accum.sv
// Bounded signed offset register with refusal flag.
module phase_ofs_accum #(
  parameter int OFS_W    = 9,
  parameter int OFS_MAX  = 255,
  parameter int INIT_VAL = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply,
  input  logic                    up,
  output logic signed [OFS_W-1:0] ofs,
  output logic                    refused
);

  localparam logic signed [OFS_W-1:0] TOP    = OFS_W'(OFS_MAX);
  localparam logic signed [OFS_W-1:0] BOT    = -TOP;
  localparam logic signed [OFS_W-1:0] ONE    = OFS_W'(1);
  localparam logic signed [OFS_W-1:0] INIT_Q = OFS_W'(INIT_VAL);

  logic signed [OFS_W-1:0] ofs_q, ofs_d;
  logic                    ref_q, ref_d;
  logic                    blocked, ofs_en;

  always_comb begin
    blocked = up ? (ofs_q == TOP) : (ofs_q == BOT);
    ofs_d   = ofs_q;
    ref_d   = ref_q;
    ofs_en  = 1'b0;
    if (apply) begin
      if (blocked) begin
        ref_d = 1'b1;
      end else begin
        ofs_d  = up ? (ofs_q + ONE) : (ofs_q - ONE);
        ofs_en = 1'b1;
        ref_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= INIT_Q;
    end else if (ofs_en) begin
      ofs_q <= ofs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else if (apply) begin
      ref_q <= ref_d;
    end
  end

  assign ofs     = ofs_q;
  assign refused = ref_q;

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter ps_mode_e    MODE     = PS_STEP,
  parameter int          INIT_OFS = 0,
  parameter int unsigned LATENCY  = 2
) (
  input  logic              ctl_clk,
  input  logic              ctl_rst_n,
  input  logic              step_req,
  input  logic              step_up,
  output logic signed [8:0] phase_ofs,
  output logic              step_done,
  output logic              ofs_refused
);

  localparam int OFS_MAX   = 255;
  localparam int OFS_W     = $clog2(OFS_MAX + 1) + 1;
  localparam int RESET_OFS = (MODE == PS_OFF) ? 0 : clamp_ofs(INIT_OFS, OFS_MAX);
  localparam logic STEP_ON = (MODE == PS_STEP);

  logic apply, apply_up;

  phase_step_seq #(.LATENCY(LATENCY)) u_seq (
    .clk      (ctl_clk),
    .rst_n    (ctl_rst_n),
    .arm      (STEP_ON),
    .req      (step_req),
    .up       (step_up),
    .apply    (apply),
    .apply_up (apply_up),
    .done     (step_done)
  );

  phase_ofs_accum #(
    .OFS_W    (OFS_W),
    .OFS_MAX  (OFS_MAX),
    .INIT_VAL (RESET_OFS)
  ) u_accum (
    .clk     (ctl_clk),
    .rst_n   (ctl_rst_n),
    .apply   (apply),
    .up      (apply_up),
    .ofs     (phase_ofs),
    .refused (ofs_refused)
  );

endmodule

// File: rtl/phase_step_ctrl_chk.sv
module phase_step_ctrl_chk
  import phase_step_pkg::*;
#(
  parameter ps_mode_e MODE = PS_STEP
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [8:0] phase_ofs,
  input logic              step_done,
  input logic              ofs_refused
);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  assert_move_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_ofs) |-> step_done);

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_ofs <= 9'sd255) && (phase_ofs >= -9'sd255));

  assert_refused_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && ofs_refused) |-> $stable(phase_ofs));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !ofs_refused) |->
      ((phase_ofs == $past(phase_ofs) + 9'sd1) || (phase_ofs == $past(phase_ofs) - 9'sd1)));

  generate
    if (MODE != PS_STEP) begin : g_static
      assert_no_done_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_done);
    end
  endgenerate

endmodule

bind phase_step_ctrl phase_step_ctrl_chk #(.MODE(MODE)) u_chk (
  .clk         (ctl_clk),
  .rst_n       (ctl_rst_n),
  .phase_ofs   (phase_ofs),
  .step_done   (step_done),
  .ofs_refused (ofs_refused)
);

// File: tb/phase_step_ctrl_test.sv
`timescale 1ns/1ps
module phase_step_ctrl_test;
  import phase_step_pkg::*;

  localparam int LAT      = 3;
  localparam int INIT_V   = 250;
  localparam int INIT_FIX = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic step_req, step_up;
  logic signed [8:0] v_ofs, f_ofs, o_ofs;
  logic v_done, f_done, o_done;
  logic v_ref, f_ref, o_ref;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_ofs;
  int exp_ref;
  bit ended = 0;

  always #2.5 clk = ~clk;

  phase_step_ctrl #(.MODE(PS_STEP), .INIT_OFS(INIT_V), .LATENCY(LAT)) uut (
    .ctl_clk(clk), .ctl_rst_n(rst_n), .step_req(step_req), .step_up(step_up),
    .phase_ofs(v_ofs), .step_done(v_done), .ofs_refused(v_ref));

  phase_step_ctrl #(.MODE(PS_FIXED), .INIT_OFS(INIT_FIX), .LATENCY(LAT)) uut_fix (
    .ctl_clk(clk), .ctl_rst_n(rst_n), .step_req(step_req), .step_up(step_up),
    .phase_ofs(f_ofs), .step_done(f_done), .ofs_refused(f_ref));

  phase_step_ctrl #(.MODE(PS_OFF), .INIT_OFS(77), .LATENCY(LAT)) uut_off (
    .ctl_clk(clk), .ctl_rst_n(rst_n), .step_req(step_req), .step_up(step_up),
    .phase_ofs(o_ofs), .step_done(o_done), .ofs_refused(o_ref));

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model of one completed step (R2, R3, R4)
  function automatic void model_step(bit up);
    if (up) begin
      if (exp_ofs == 255) exp_ref = 1;
      else begin exp_ofs++; exp_ref = 0; end
    end else begin
      if (exp_ofs == -255) exp_ref = 1;
      else begin exp_ofs--; exp_ref = 0; end
    end
  endfunction

  // Static and off instances must never move (R7)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !ended) begin
      chk("R7 static done", int'(f_done), 0);
      chk("R7 static offset", int'(f_ofs), INIT_FIX);
      chk("R7 off done", int'(o_done), 0);
      chk("R7 off offset", int'(o_ofs), 0);
    end
  end

  task automatic do_step(bit up, bit noise);
    int cyc;
    @(negedge clk);
    step_req = 1'b1;
    step_up  = up;
    @(negedge clk);
    model_step(up);
    cyc = 0;
    while (!v_done && cyc < 20) begin
      if (noise) begin
        step_req = 1'($urandom % 2);
        step_up  = 1'($urandom % 2);
      end else begin
        step_req = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    step_req = 1'b0;
    chk("R5 latency", cyc, LAT);
    chk("R2 R3 offset", int'(v_ofs), exp_ofs);
    chk("R3 R4 refused", int'(v_ref), exp_ref);
    @(negedge clk);
    chk("R5 single done", int'(v_done), 0);
    chk("R6 ignored pulse offset", int'(v_ofs), exp_ofs);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk("R6 idle done", int'(v_done), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0;
    step_req = 1'b0;
    step_up = 1'b0;
    exp_ofs = INIT_V;
    exp_ref = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset offset", int'(v_ofs), INIT_V);
    chk("R1 reset done", int'(v_done), 0);
    chk("R1 reset refused", int'(v_ref), 0);
    chk("R1 static reset", int'(f_ofs), INIT_FIX);
    chk("R1 off reset", int'(o_ofs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(v_ofs), INIT_V);

    // Direction without request has no effect (R6)
    for (int i = 0; i < 6; i++) begin
      step_up = 1'($urandom % 2);
      @(negedge clk);
      chk("R6 direction only", int'(v_ofs), INIT_V);
    end

    // Climb into the upper bound (R3), then release it (R4)
    for (int i = 0; i < 8; i++) do_step(1'b1, 1'b0);
    chk("R3 top held", int'(v_ofs), 255);
    do_step(1'b1, 1'b1);
    do_step(1'b0, 1'b0);
    chk("R4 refusal cleared", int'(v_ref), 0);

    // Descend through the whole window into the lower bound, noisy requests (R3 R6)
    for (int i = 0; i < 515; i++) do_step(1'b0, 1'b1);
    chk("R3 bottom held", int'(v_ofs), -255);
    chk("R3 bottom refused", int'(v_ref), 1);

    // Mixed random traffic
    for (int i = 0; i < 300; i++) do_step(1'($urandom % 2), 1'($urandom % 2));

    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!ended) begin
      ended = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule